// File: doc/BRIEF.md
# Multi-Segment Carry-Select Adder

This block adds two unsigned 16-bit operands and a carry input. The operand width is split into three segments of unequal width, by default 5, 5 and 6 bits from the least significant end. The lowest segment is one ripple adder fed by the external carry input. Each higher segment holds two ripple adders that work side by side, one assuming an incoming carry of 0 and one assuming 1. When the carry leaving the segment below is known, it picks both the sum bits and the outgoing carry of the segment above. These picks form a serial chain of multiplexers from the bottom segment to the top one, so no carry has to ripple across a segment boundary.

The selected carry of the top segment is the final carry output and reports unsigned overflow. For M equal segments of an N-bit adder the modelled delay is 2*(N/M) + 2*(M-1) gate delays, compared with 2N for a single ripple chain. The sum and the carry are captured in an output register. A synchronous, active-high reset clears that register. The segment widths are parameters, and elaboration stops if they do not add up to the total width.

Top module: `csel_adder`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `sum_o` and `cout_o` are both 0 after that edge, whatever the operands are.
- R2: After a rising edge with `rst` low, the 17-bit value {`cout_o`, `sum_o`} equals `a_i` + `b_i` + `cin_i` as sampled at that edge. The output therefore lags the inputs by one clock.
- R3: `cout_o` is the carry out of bit 15 (unsigned overflow). It is 1 exactly when `a_i` + `b_i` + `cin_i` is 65536 or more. For example, 0xFFFF + 0x0000 + 1 gives `sum_o` = 0x0000 and `cout_o` = 1.
- R4: A carry that leaves the low segment (bits 4:0) is taken into the middle segment (bits 9:5). For example, 0x001F + 0x0001 gives 0x0020, and 0x001F + 0x0000 with `cin_i` = 1 also gives 0x0020.
- R5: A carry that leaves the middle segment (bits 9:5) is taken into the top segment (bits 15:10). For example, 0x03FF + 0x0001 gives 0x0400, and 0x03E0 + 0x0020 gives 0x0400.
- R6: A carry that `cin_i` starts can cross every segment boundary in the same add. For example, 0xFFFF + 0x0000 + 1 gives 0x0000 with a carry out, and 0x7FFF + 0x0000 + 1 gives 0x8000 with no carry out.
- R7: All-ones operands give the largest result: 0xFFFF + 0xFFFF + 1 gives `sum_o` = 0xFFFF and `cout_o` = 1. With `cin_i` = 0 the result is 0xFFFE with `cout_o` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the result register loads on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the result register |
| a_i | input | 16 | First unsigned operand |
| b_i | input | 16 | Second unsigned operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Registered sum bits |
| cout_o | output | 1 | Registered carry out of bit 15 (unsigned overflow) |

## Verification
Two functions can fall in the same cycle. A carry selection that crosses a segment boundary can coincide with the overflow carry leaving the top segment, when a single carry travels through every multiplexer in the chain during one add. The bench provokes this with operands such as 0xFFFF plus a carry input of 1, and with all-ones operands. It judges {`cout_o`, `sum_o`} against the 17-bit sum it computes itself, one clock after the operands are applied. The bench also applies a reset while an add that overflows is present at the inputs, and expects the cleared value to take precedence.

// File: rtl/csel_pkg.sv
package csel_pkg;

  typedef struct packed {
    logic carry;
    logic sum;
  } bit_add_t;

  function automatic bit_add_t full_add(input logic x, input logic y, input logic ci);
    bit_add_t r;
    r.sum   = x ^ y ^ ci;
    r.carry = (x & y) | (x & ci) | (y & ci);
    return r;
  endfunction

endpackage

// File: rtl/csel_ripple.sv
module csel_ripple #(
  parameter int W = 5
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         ci_i,
  output logic [W-1:0] s_o,
  output logic         co_o
);
  import csel_pkg::*;

  logic [W:0] chain;
  assign chain[0] = ci_i;

  for (genvar k = 0; k < W; k++) begin : g_bit
    bit_add_t fa;
    assign fa          = full_add(x_i[k], y_i[k], chain[k]);
    assign s_o[k]      = fa.sum;
    assign chain[k+1]  = fa.carry;
  end

  assign co_o = chain[W];

  // R2: every ripple slice adds exactly
  always_comb begin
    if (!$isunknown({x_i, y_i, ci_i}))
      p_ripple_sum_r2: assert ({co_o, s_o} == ({1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, ci_i}))
        else $error("ripple slice sum mismatch");
  end

endmodule

// File: rtl/csel_segment.sv
module csel_segment #(
  parameter int W    = 5,
  parameter bit DUAL = 1'b1
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         ci_i,
  output logic [W-1:0] s_o,
  output logic         co_o
);

  if (DUAL) begin : g_dual
    logic [W-1:0] s_lo, s_hi;
    logic         c_lo, c_hi;

    csel_ripple #(.W(W)) u_assume0 (
      .x_i(x_i), .y_i(y_i), .ci_i(1'b0), .s_o(s_lo), .co_o(c_lo)
    );
    csel_ripple #(.W(W)) u_assume1 (
      .x_i(x_i), .y_i(y_i), .ci_i(1'b1), .s_o(s_hi), .co_o(c_hi)
    );

    assign s_o  = ci_i ? s_hi : s_lo;
    assign co_o = ci_i ? c_hi : c_lo;

    // R4 R5: an assumed carry of 1 never yields less than one of 0
    always_comb begin
      if (!$isunknown({x_i, y_i}))
        p_seg_order_r5: assert ({c_hi, s_hi} == {c_lo, s_lo} + {{W{1'b0}}, 1'b1})
          else $error("dual ripple results disagree");
    end
  end else begin : g_single
    csel_ripple #(.W(W)) u_only (
      .x_i(x_i), .y_i(y_i), .ci_i(ci_i), .s_o(s_o), .co_o(co_o)
    );
  end

  // R4: the selected segment result is the true segment sum
  always_comb begin
    if (!$isunknown({x_i, y_i, ci_i}))
      p_seg_sum_r4: assert ({co_o, s_o} == ({1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, ci_i}))
        else $error("segment select mismatch");
  end

endmodule

// File: rtl/csel_adder.sv
module csel_adder #(
  parameter int WIDTH  = 16,
  parameter int SEG_W0 = 5,
  parameter int SEG_W1 = 5,
  parameter int SEG_W2 = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  localparam int NSEG = 3;
  localparam int LO1  = SEG_W0;
  localparam int LO2  = SEG_W0 + SEG_W1;
  localparam int HI2  = LO2 + SEG_W2;

  if (HI2 != WIDTH) begin : g_bad_split
    $error("segment widths must add up to WIDTH");
  end

  logic [NSEG:0]    seg_c;
  logic [WIDTH-1:0] sum_d;

  assign seg_c[0] = cin_i;

  csel_segment #(.W(SEG_W0), .DUAL(1'b0)) u_seg0 (
    .x_i(a_i[LO1-1:0]), .y_i(b_i[LO1-1:0]), .ci_i(seg_c[0]),
    .s_o(sum_d[LO1-1:0]), .co_o(seg_c[1])
  );
  csel_segment #(.W(SEG_W1), .DUAL(1'b1)) u_seg1 (
    .x_i(a_i[LO2-1:LO1]), .y_i(b_i[LO2-1:LO1]), .ci_i(seg_c[1]),
    .s_o(sum_d[LO2-1:LO1]), .co_o(seg_c[2])
  );
  csel_segment #(.W(SEG_W2), .DUAL(1'b1)) u_seg2 (
    .x_i(a_i[WIDTH-1:LO2]), .y_i(b_i[WIDTH-1:LO2]), .ci_i(seg_c[2]),
    .s_o(sum_d[WIDTH-1:LO2]), .co_o(seg_c[3])
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o  <= '0;
      cout_o <= 1'b0;
    end else begin
      sum_o  <= sum_d;
      cout_o <= seg_c[NSEG];
    end
  end

  // one cycle of history exists after a non-reset edge
  logic primed_q = 1'b0;
  always_ff @(posedge clk) primed_q <= ~rst;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (sum_o == '0 && cout_o == 1'b0))
    else $error("outputs not cleared by reset");

  p_sum_match_r2: assert property (@(posedge clk) disable iff (rst)
    primed_q |-> ({cout_o, sum_o} ==
      ({1'b0, $past(a_i)} + {1'b0, $past(b_i)} + {{WIDTH{1'b0}}, $past(cin_i)})))
    else $error("registered sum mismatch");

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (primed_q && (({1'b0, $past(a_i)} + {1'b0, $past(b_i)}
                   + {{WIDTH{1'b0}}, $past(cin_i)}) < (1 << WIDTH))) |-> !cout_o)
    else $error("carry out raised without overflow");

endmodule

// File: tb/sim_csel_adder.sv
module sim_csel_adder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] a = '0, b = '0;
  logic        cin = 1'b0;
  logic [15:0] sum;
  logic        cout;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  csel_adder u0 (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .cin_i(cin),
    .sum_o(sum), .cout_o(cout)
  );

  task automatic check(input string req, input logic [16:0] got, input logic [16:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %05h expected %05h", req, got, exp);
    end
  endtask

  // apply operands at a falling edge, read one rising edge later
  task automatic add_and_check(input string req, input logic [15:0] x,
                               input logic [15:0] y, input logic c);
    logic [16:0] exp;
    exp = {1'b0, x} + {1'b0, y} + {16'd0, c};
    @(negedge clk);
    a = x; b = y; cin = c;
    @(posedge clk);
    @(negedge clk);
    check(req, {cout, sum}, exp);
  endtask

  task automatic t_reset_r1();
    @(negedge clk);
    rst = 1'b1; a = 16'hFFFF; b = 16'hFFFF; cin = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 reset with overflow inputs", {cout, sum}, 17'h0);
    rst = 1'b0;
  endtask

  task automatic t_boundary_low_r4();
    add_and_check("R4 low->mid", 16'h001F, 16'h0001, 1'b0);
    add_and_check("R4 low->mid via cin", 16'h001F, 16'h0000, 1'b1);
    add_and_check("R4 no carry", 16'h000F, 16'h0010, 1'b0);
  endtask

  task automatic t_boundary_mid_r5();
    add_and_check("R5 mid->top", 16'h03FF, 16'h0001, 1'b0);
    add_and_check("R5 mid only", 16'h03E0, 16'h0020, 1'b0);
    add_and_check("R5 no carry", 16'h01FF, 16'h0200, 1'b0);
  endtask

  task automatic t_overflow_r3();
    add_and_check("R3 overflow", 16'hFFFF, 16'h0000, 1'b1);
    add_and_check("R3 top only", 16'h8000, 16'h8000, 1'b0);
    add_and_check("R3 just below", 16'hFFFE, 16'h0000, 1'b1);
  endtask

  task automatic t_full_ripple_r6();
    add_and_check("R6 through all", 16'hFFFF, 16'h0000, 1'b1);
    add_and_check("R6 to msb", 16'h7FFF, 16'h0000, 1'b1);
    add_and_check("R6 split ones", 16'hAAAA, 16'h5555, 1'b1);
  endtask

  task automatic t_all_ones_r7();
    add_and_check("R7 ones cin1", 16'hFFFF, 16'hFFFF, 1'b1);
    add_and_check("R7 ones cin0", 16'hFFFF, 16'hFFFF, 1'b0);
  endtask

  task automatic t_random_r2();
    for (int i = 0; i < 200; i++)
      add_and_check("R2 random", 16'($urandom), 16'($urandom), 1'($urandom));
    add_and_check("R2 zero", 16'h0000, 16'h0000, 1'b0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 initial reset", {cout, sum}, 17'h0);
    rst = 1'b0;
    t_boundary_low_r4();
    t_boundary_mid_r5();
    t_overflow_r3();
    t_full_ripple_r6();
    t_all_ones_r7();
    t_reset_r1();
    t_random_r2();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule